// File: doc/BRIEF.md
# Three-Wire Serial Register Loader

This block receives configuration words for a dual-loop frequency synthesizer over a three-wire port made of a serial data line, a serial clock and a load-enable strobe. All three lines are asynchronous to the block. They are brought into the fast system clock domain by synchronizer chains, and their edges are found by comparing each synchronized line with its value one cycle earlier. While load-enable is low, each rising serial-clock edge shifts one data bit into a 23-bit frame register. The frame is sent most significant position first, so the bit sent last becomes frame position 1.

When load-enable rises, the two lowest frame positions select one of four destination latches. Two of these are reference-divider latches, one for the IF loop and one for the RF loop. The other two are program latches, again one per loop. The frame fields are copied into the selected latch, and that destination's load strobe pulses for one cycle. A small controller sequences the work through three states. SHIFT accepts serial-clock edges. It moves to LOAD on a load-enable rising edge. LOAD commits the frame for one cycle, then moves to HOLD if load-enable is still high, or back to SHIFT if it is already low. HOLD ignores serial-clock edges and returns to SHIFT when load-enable falls.

Top module: `ser_prog_loader`

## Requirements
- R1: On each synchronized rising edge of `ser_clk_i` while `ser_le_i` is low, the frame register shifts left by one and takes `ser_data_i` into position 1. Only the 23 most recent bits are kept, so earlier bits are lost.
- R2: The destination is chosen by the pair (position 1, position 2). The value 00 selects the IF reference latch, 10 the RF reference latch, 01 the IF program latch and 11 the RF program latch.
- R3: A reference frame carries its fields at these positions: 3 goes to `*_ref_mon_sel[0]`, 4 goes to `*_ref_mon_sel[1]`, 5 through 18 form the 14-bit ratio with position 5 as its LSB, and 19 is the current-select bit. Positions 20 to 23 have no effect.
- R4: A program frame carries its fields at these positions: 3 is the monitor-enable bit, 4 is the modulus-select bit, 5 is the phase-polarity bit, 6 through 12 form the 7-bit swallow count with position 6 as its LSB, and 13 through 23 form the 11-bit main count with position 13 as its LSB.
- R5: Latches change only on a rising edge of `ser_le_i`. The three latches that are not selected keep their values.
- R6: Serial-clock edges that arrive while `ser_le_i` is high leave the frame register unchanged. Raising `ser_le_i` again therefore reloads the same frame into the same latch.
- R7: After reset, both reference ratios read 3, both main counts read 3, both swallow counts read 0, and every single-bit field reads 0.
- R8: Each latch update drives a single-cycle pulse on its own bit of `load_strobe_o`: bit 0 for IF reference, bit 1 for RF reference, bit 2 for IF program and bit 3 for RF program. At most one bit is high in any cycle, and holding `ser_le_i` high does not produce further pulses.
- R9: A current-select bit of 1 drives `*_ref_cp_hi` high, which selects the high charge-pump current. A bit of 0 drives it low, which selects the low current.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_data_i | input | 1 | Serial data line |
| ser_clk_i | input | 1 | Serial shift clock |
| ser_le_i | input | 1 | Load-enable line |
| if_ref_ratio_o | output | 14 | IF reference divide ratio |
| if_ref_cp_hi_o | output | 1 | IF charge-pump high-current select |
| if_ref_mon_sel_o | output | 2 | IF monitor output select bits |
| rf_ref_ratio_o | output | 14 | RF reference divide ratio |
| rf_ref_cp_hi_o | output | 1 | RF charge-pump high-current select |
| rf_ref_mon_sel_o | output | 2 | RF monitor output select bits |
| if_prg_count_o | output | 11 | IF main counter ratio |
| if_prg_swallow_o | output | 7 | IF swallow counter ratio |
| if_prg_mon_en_o | output | 1 | IF monitor-enable bit |
| if_prg_mod_hi_o | output | 1 | IF prescaler modulus select |
| if_prg_pol_o | output | 1 | IF phase-detector polarity |
| rf_prg_count_o | output | 11 | RF main counter ratio |
| rf_prg_swallow_o | output | 7 | RF swallow counter ratio |
| rf_prg_mon_en_o | output | 1 | RF monitor-enable bit |
| rf_prg_mod_hi_o | output | 1 | RF prescaler modulus select |
| rf_prg_pol_o | output | 1 | RF phase-detector polarity |
| load_strobe_o | output | 4 | One-cycle update pulse per destination |

## Verification
The bench sweeps boundary ratios through every destination: 3, 16383 and alternating-bit patterns for the reference ratio, and 0, 127, 3 and 2047 for the counts. A field placed at the wrong position, or a swapped control-bit order, would put these values into the wrong output or the wrong latch. To catch a register that accepts clocks during a transfer, the bench toggles a whole second frame while load-enable is high and then reloads. A design that did not ignore those edges would deliver the second frame instead of repeating the first. Leading surplus bits and a long load-enable pulse are also sent. These expose a register shorter than 23 bits, and repeated or missing strobes.

// File: rtl/sp_pkg.sv
package sp_pkg;

    localparam int FRAME_W  = 23;
    localparam int REF_W    = 14;
    localparam int SWAL_W   = 7;
    localparam int CNT_W    = 11;
    localparam int DST_N    = 4;
    localparam int LOOP_N   = 2;

    // reset values: smallest legal ratios
    localparam logic [REF_W-1:0]  REF_RST  = REF_W'(3);
    localparam logic [CNT_W-1:0]  CNT_RST  = CNT_W'(3);
    localparam logic [SWAL_W-1:0] SWAL_RST = '0;

    // destination index = {position2, position1}
    typedef enum logic [1:0] {
        DST_IF_REF  = 2'd0,
        DST_RF_REF  = 2'd1,
        DST_IF_PROG = 2'd2,
        DST_RF_PROG = 2'd3
    } dst_e;

    typedef struct packed {
        logic [REF_W-1:0] ratio;
        logic             cp_hi;
        logic [1:0]       mon_sel;
    } ref_cfg_t;

    typedef struct packed {
        logic [CNT_W-1:0]  count;
        logic [SWAL_W-1:0] swallow;
        logic              mon_en;
        logic              mod_hi;
        logic              pol;
    } prog_cfg_t;

    // frame position k lives at bit k-1
    function automatic dst_e frame_dst(input logic [FRAME_W-1:0] f);
        return dst_e'({f[1], f[0]});
    endfunction

    function automatic ref_cfg_t decode_ref(input logic [FRAME_W-1:0] f);
        ref_cfg_t r;
        r.mon_sel = {f[3], f[2]};
        r.ratio   = f[4 +: REF_W];
        r.cp_hi   = f[4 + REF_W];
        return r;
    endfunction

    function automatic prog_cfg_t decode_prog(input logic [FRAME_W-1:0] f);
        prog_cfg_t p;
        p.mon_en  = f[2];
        p.mod_hi  = f[3];
        p.pol     = f[4];
        p.swallow = f[5 +: SWAL_W];
        p.count   = f[5 + SWAL_W +: CNT_W];
        return p;
    endfunction

    function automatic ref_cfg_t ref_reset();
        ref_cfg_t r;
        r.ratio   = REF_RST;
        r.cp_hi   = 1'b0;
        r.mon_sel = 2'b00;
        return r;
    endfunction

    function automatic prog_cfg_t prog_reset();
        prog_cfg_t p;
        p.count   = CNT_RST;
        p.swallow = SWAL_RST;
        p.mon_en  = 1'b0;
        p.mod_hi  = 1'b0;
        p.pol     = 1'b0;
        return p;
    endfunction

endpackage

// File: rtl/sp_in_sync.sv
module sp_in_sync #(
    parameter int LANES  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] raw_i,
    output logic [LANES-1:0] level_o,
    output logic [LANES-1:0] rise_o,
    output logic [LANES-1:0] fall_o
);

    generate
        for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
            logic [STAGES-1:0] chain_q;
            logic              prev_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain_q <= '0;
                    prev_q  <= 1'b0;
                end else begin
                    chain_q <= {chain_q[STAGES-2:0], raw_i[ln]};
                    prev_q  <= chain_q[STAGES-1];
                end
            end

            assign level_o[ln] = chain_q[STAGES-1];
            assign rise_o[ln]  = chain_q[STAGES-1] & ~prev_q;
            assign fall_o[ln]  = ~chain_q[STAGES-1] & prev_q;
        end
    endgenerate

endmodule

// File: rtl/sp_shift_reg.sv
module sp_shift_reg #(
    parameter int WIDTH = 23
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_en,
    input  logic             bit_in,
    output logic [WIDTH-1:0] frame_o
);

    logic [WIDTH-1:0] sr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else if (shift_en) begin
            sr_q <= {sr_q[WIDTH-2:0], bit_in};
        end
    end

    assign frame_o = sr_q;

endmodule

// File: rtl/sp_ctrl_fsm.sv
module sp_ctrl_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic le_level,
    input  logic le_rise,
    input  logic le_fall,
    input  logic sclk_rise,
    output logic shift_en,
    output logic commit
);

    typedef enum logic [1:0] {
        ST_SHIFT = 2'd0,
        ST_LOAD  = 2'd1,
        ST_HOLD  = 2'd2
    } state_e;

    state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_SHIFT;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SHIFT: if (le_rise) state_d = ST_LOAD;
            ST_LOAD:  state_d = le_level ? ST_HOLD : ST_SHIFT;
            ST_HOLD:  if (le_fall) state_d = ST_SHIFT;
            default:  state_d = ST_SHIFT;
        endcase
    end

    always_comb begin
        shift_en = 1'b0;
        commit   = 1'b0;
        unique case (state_q)
            ST_SHIFT: shift_en = sclk_rise & ~le_level;
            ST_LOAD:  commit   = 1'b1;
            ST_HOLD:  ;
            default:  ;
        endcase
    end

endmodule

// File: rtl/sp_latch_bank.sv
module sp_latch_bank
    import sp_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 commit,
    input  logic [FRAME_W-1:0]   frame,
    output ref_cfg_t             ref_cfg_o  [LOOP_N],
    output prog_cfg_t            prog_cfg_o [LOOP_N],
    output logic [DST_N-1:0]     strobe_o
);

    dst_e      dst;
    ref_cfg_t  ref_new;
    prog_cfg_t prog_new;

    assign dst      = frame_dst(frame);
    assign ref_new  = decode_ref(frame);
    assign prog_new = decode_prog(frame);

    generate
        for (genvar lp = 0; lp < LOOP_N; lp++) begin : g_loop
            localparam int REF_IDX  = lp;
            localparam int PROG_IDX = LOOP_N + lp;
            ref_cfg_t  ref_q;
            prog_cfg_t prog_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    ref_q <= ref_reset();
                end else if (commit && (int'(dst) == REF_IDX)) begin
                    ref_q <= ref_new;
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    prog_q <= prog_reset();
                end else if (commit && (int'(dst) == PROG_IDX)) begin
                    prog_q <= prog_new;
                end
            end

            assign ref_cfg_o[lp]  = ref_q;
            assign prog_cfg_o[lp] = prog_q;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            strobe_o <= '0;
        end else begin
            strobe_o <= commit ? (DST_N'(1) << dst) : '0;
        end
    end

endmodule

// File: rtl/ser_prog_loader.sv
module ser_prog_loader
    import sp_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_data_i,
    input  logic              ser_clk_i,
    input  logic              ser_le_i,
    output logic [REF_W-1:0]  if_ref_ratio_o,
    output logic              if_ref_cp_hi_o,
    output logic [1:0]        if_ref_mon_sel_o,
    output logic [REF_W-1:0]  rf_ref_ratio_o,
    output logic              rf_ref_cp_hi_o,
    output logic [1:0]        rf_ref_mon_sel_o,
    output logic [CNT_W-1:0]  if_prg_count_o,
    output logic [SWAL_W-1:0] if_prg_swallow_o,
    output logic              if_prg_mon_en_o,
    output logic              if_prg_mod_hi_o,
    output logic              if_prg_pol_o,
    output logic [CNT_W-1:0]  rf_prg_count_o,
    output logic [SWAL_W-1:0] rf_prg_swallow_o,
    output logic              rf_prg_mon_en_o,
    output logic              rf_prg_mod_hi_o,
    output logic              rf_prg_pol_o,
    output logic [DST_N-1:0]  load_strobe_o
);

    localparam int L_DATA = 0;
    localparam int L_SCLK = 1;
    localparam int L_LE   = 2;

    logic [2:0] lvl, rise, fall;
    logic       shift_en, commit;
    logic [FRAME_W-1:0] frame;
    ref_cfg_t  ref_cfg  [LOOP_N];
    prog_cfg_t prog_cfg [LOOP_N];

    sp_in_sync #(.LANES(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .raw_i   ({ser_le_i, ser_clk_i, ser_data_i}),
        .level_o (lvl),
        .rise_o  (rise),
        .fall_o  (fall)
    );

    sp_ctrl_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .le_level  (lvl[L_LE]),
        .le_rise   (rise[L_LE]),
        .le_fall   (fall[L_LE]),
        .sclk_rise (rise[L_SCLK]),
        .shift_en  (shift_en),
        .commit    (commit)
    );

    sp_shift_reg #(.WIDTH(FRAME_W)) u_sr (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (shift_en),
        .bit_in   (lvl[L_DATA]),
        .frame_o  (frame)
    );

    sp_latch_bank u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .commit     (commit),
        .frame      (frame),
        .ref_cfg_o  (ref_cfg),
        .prog_cfg_o (prog_cfg),
        .strobe_o   (load_strobe_o)
    );

    assign if_ref_ratio_o   = ref_cfg[0].ratio;
    assign if_ref_cp_hi_o   = ref_cfg[0].cp_hi;
    assign if_ref_mon_sel_o = ref_cfg[0].mon_sel;
    assign rf_ref_ratio_o   = ref_cfg[1].ratio;
    assign rf_ref_cp_hi_o   = ref_cfg[1].cp_hi;
    assign rf_ref_mon_sel_o = ref_cfg[1].mon_sel;

    assign if_prg_count_o   = prog_cfg[0].count;
    assign if_prg_swallow_o = prog_cfg[0].swallow;
    assign if_prg_mon_en_o  = prog_cfg[0].mon_en;
    assign if_prg_mod_hi_o  = prog_cfg[0].mod_hi;
    assign if_prg_pol_o     = prog_cfg[0].pol;
    assign rf_prg_count_o   = prog_cfg[1].count;
    assign rf_prg_swallow_o = prog_cfg[1].swallow;
    assign rf_prg_mon_en_o  = prog_cfg[1].mon_en;
    assign rf_prg_mod_hi_o  = prog_cfg[1].mod_hi;
    assign rf_prg_pol_o     = prog_cfg[1].pol;

endmodule

// File: rtl/sp_loader_chk.sv
module sp_loader_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [13:0] if_ref_ratio_o,
    input logic        if_ref_cp_hi_o,
    input logic [13:0] rf_ref_ratio_o,
    input logic [10:0] if_prg_count_o,
    input logic [10:0] rf_prg_count_o,
    input logic [6:0]  rf_prg_swallow_o,
    input logic [3:0]  load_strobe_o
);

    AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(load_strobe_o)); // R8

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (load_strobe_o != 4'b0) |=> (load_strobe_o == 4'b0)); // R8

    AST_IF_REF_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !load_strobe_o[0] |-> ($stable(if_ref_ratio_o) && $stable(if_ref_cp_hi_o))); // R5

    AST_RF_REF_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !load_strobe_o[1] |-> $stable(rf_ref_ratio_o)); // R5

    AST_IF_PRG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !load_strobe_o[2] |-> $stable(if_prg_count_o)); // R5

    AST_RF_PRG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !load_strobe_o[3] |-> ($stable(rf_prg_count_o) && $stable(rf_prg_swallow_o))); // R5

endmodule

bind ser_prog_loader sp_loader_chk chk_i (
    .clk              (clk),
    .rst_n            (rst_n),
    .if_ref_ratio_o   (if_ref_ratio_o),
    .if_ref_cp_hi_o   (if_ref_cp_hi_o),
    .rf_ref_ratio_o   (rf_ref_ratio_o),
    .if_prg_count_o   (if_prg_count_o),
    .rf_prg_count_o   (rf_prg_count_o),
    .rf_prg_swallow_o (rf_prg_swallow_o),
    .load_strobe_o    (load_strobe_o)
);

// File: tb/ser_prog_loader_tb_top.sv
module ser_prog_loader_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sd = 1'b0, sc = 1'b0, le = 1'b0;

    logic [13:0] ifr_ratio, rfr_ratio;
    logic        ifr_cp, rfr_cp;
    logic [1:0]  ifr_mon, rfr_mon;
    logic [10:0] ifp_cnt, rfp_cnt;
    logic [6:0]  ifp_sw, rfp_sw;
    logic        ifp_me, ifp_mh, ifp_pol, rfp_me, rfp_mh, rfp_pol;
    logic [3:0]  strobe;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    bit done = 0;
    int scnt [4];

    // bench model: {ratio, cp, mon} per ref latch; {count, swallow, me, mh, pol} per prog latch
    logic [16:0] exp_ref  [2];
    logic [20:0] exp_prog [2];
    int          exp_scnt [4];

    always #2 clk = ~clk;

    ser_prog_loader dut_i (
        .clk(clk), .rst_n(rst_n), .ser_data_i(sd), .ser_clk_i(sc), .ser_le_i(le),
        .if_ref_ratio_o(ifr_ratio), .if_ref_cp_hi_o(ifr_cp), .if_ref_mon_sel_o(ifr_mon),
        .rf_ref_ratio_o(rfr_ratio), .rf_ref_cp_hi_o(rfr_cp), .rf_ref_mon_sel_o(rfr_mon),
        .if_prg_count_o(ifp_cnt), .if_prg_swallow_o(ifp_sw), .if_prg_mon_en_o(ifp_me),
        .if_prg_mod_hi_o(ifp_mh), .if_prg_pol_o(ifp_pol),
        .rf_prg_count_o(rfp_cnt), .rf_prg_swallow_o(rfp_sw), .rf_prg_mon_en_o(rfp_me),
        .rf_prg_mod_hi_o(rfp_mh), .rf_prg_pol_o(rfp_pol),
        .load_strobe_o(strobe)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst_n) for (int i = 0; i < 4; i++) if (strobe[i]) scnt[i] <= scnt[i] + 1;
        if (cyc > 150000 && !done) begin
            done = 1;
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        @(negedge clk);
        chk({tag, " R3 if_ref"}, 32'({ifr_ratio, ifr_cp, ifr_mon}), 32'(exp_ref[0]));
        chk({tag, " R3 rf_ref"}, 32'({rfr_ratio, rfr_cp, rfr_mon}), 32'(exp_ref[1]));
        chk({tag, " R4 if_prg"}, 32'({ifp_cnt, ifp_sw, ifp_me, ifp_mh, ifp_pol}), 32'(exp_prog[0]));
        chk({tag, " R4 rf_prg"}, 32'({rfp_cnt, rfp_sw, rfp_me, rfp_mh, rfp_pol}), 32'(exp_prog[1]));
        for (int i = 0; i < 4; i++) chk({tag, " R8 strobe count"}, 32'(scnt[i]), 32'(exp_scnt[i]));
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic shift_bit(input logic b);
        sd = b; wait_cyc(3);
        sc = 1'b1; wait_cyc(4);
        sc = 1'b0; wait_cyc(3);
    endtask

    // frame position k is f[k-1]; position 23 goes out first
    task automatic send_frame(input logic [22:0] f);
        for (int k = 22; k >= 0; k--) shift_bit(f[k]);
    endtask

    task automatic pulse_le(input int hold);
        wait_cyc(3);
        le = 1'b1; wait_cyc(hold);
        le = 1'b0; wait_cyc(6);
    endtask

    function automatic logic [22:0] mk_ref(input bit rf, input logic [13:0] r,
                                           input bit cs, input logic [1:0] t);
        logic [22:0] f;
        f = '0;
        f[0] = rf; f[1] = 1'b0;
        f[2] = t[0]; f[3] = t[1];
        f[17:4] = r;
        f[18] = cs;
        f[22:19] = 4'b1011; // R3: ignored tail
        return f;
    endfunction

    function automatic logic [22:0] mk_prog(input bit rf, input logic [6:0] a, input logic [10:0] n,
                                            input bit me, input bit mh, input bit pol);
        logic [22:0] f;
        f[0] = rf; f[1] = 1'b1;
        f[2] = me; f[3] = mh; f[4] = pol;
        f[11:5] = a;
        f[22:12] = n;
        return f;
    endfunction

    task automatic load_ref(input bit rf, input logic [13:0] r, input bit cs, input logic [1:0] t);
        send_frame(mk_ref(rf, r, cs, t));
        pulse_le(8);
        exp_ref[rf] = {r, cs, t};
        exp_scnt[rf]++;
        check_all("ref sweep R2 R9");
    endtask

    task automatic load_prog(input bit rf, input logic [6:0] a, input logic [10:0] n,
                             input bit me, input bit mh, input bit pol);
        send_frame(mk_prog(rf, a, n, me, mh, pol));
        pulse_le(8);
        exp_prog[rf] = {n, a, me, mh, pol};
        exp_scnt[2 + int'(rf)]++;
        check_all("prog sweep R2");
    endtask

    initial begin
        logic [13:0] rv [6];
        logic [6:0]  av [4];
        logic [10:0] nv [4];
        rv[0] = 14'd3; rv[1] = 14'd16383; rv[2] = 14'h1555; rv[3] = 14'h2AAA; rv[4] = 14'd4; rv[5] = 14'h2000;
        av[0] = 7'd0; av[1] = 7'd127; av[2] = 7'h55; av[3] = 7'd1;
        nv[0] = 11'd3; nv[1] = 11'd2047; nv[2] = 11'h2AA; nv[3] = 11'h400;
        for (int i = 0; i < 4; i++) begin scnt[i] = 0; exp_scnt[i] = 0; end
        exp_ref[0] = {14'd3, 1'b0, 2'b00};
        exp_ref[1] = {14'd3, 1'b0, 2'b00};
        exp_prog[0] = {11'd3, 7'd0, 3'b000};
        exp_prog[1] = {11'd3, 7'd0, 3'b000};

        wait_cyc(5);
        rst_n = 1'b1;
        wait_cyc(3);
        check_all("reset R7");

        // R1 R2 R3 R9: reference sweep over both loops
        for (int lp = 0; lp < 2; lp++)
            for (int i = 0; i < 6; i++)
                load_ref(lp[0], rv[i], i[0], i[1:0]);

        // R1 R2 R4: program sweep over both loops
        for (int lp = 0; lp < 2; lp++)
            for (int i = 0; i < 4; i++)
                for (int j = 0; j < 4; j++)
                    load_prog(lp[0], av[i], nv[j], j[0], j[1], i[0] ^ j[0]);

        // R1: surplus leading bits fall off the top of the register
        shift_bit(1'b1); shift_bit(1'b0); shift_bit(1'b1);
        load_ref(1'b0, 14'd1234, 1'b1, 2'b10);

        // R6: clock edges during LE high are ignored; re-raising LE reloads the same frame
        send_frame(mk_ref(1'b1, 14'd777, 1'b1, 2'b01));
        wait_cyc(3);
        le = 1'b1; wait_cyc(6);
        exp_ref[1] = {14'd777, 1'b1, 2'b01};
        exp_scnt[1]++;
        send_frame(mk_prog(1'b1, 7'd9, 11'd99, 1'b1, 1'b1, 1'b1));
        le = 1'b0; wait_cyc(6);
        check_all("R6 during high");
        pulse_le(5);
        exp_scnt[1]++;
        check_all("R6 reload same frame");

        // R5 R8: long LE high gives a single strobe
        send_frame(mk_prog(1'b0, 7'd5, 11'd50, 1'b0, 1'b1, 1'b0));
        pulse_le(60);
        exp_prog[0] = {11'd50, 7'd5, 3'b010};
        exp_scnt[2]++;
        check_all("R8 long LE");

        // R5: shifting without LE changes nothing
        send_frame(mk_ref(1'b0, 14'd9999, 1'b1, 2'b11));
        wait_cyc(10);
        check_all("R5 no LE");

        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule